// File: doc/BRIEF.md
# MDIO Management Bus Master

This controller lets a host reach the management registers of Ethernet PHYs over a two-wire MDC/MDIO serial bus. Software programs three registers through a simple write/read port: a target register that carries the PHY port, device and register fields, a command register that carries data, opcode, clock range and the busy/start flag, and a port-enable register that gates which low-numbered ports may be reached with legacy Clause 22 frames. One write of the command register with the busy bit set starts a whole transaction. The busy bit then reads back as 1 until the hardware has shifted out every frame and, for reads, captured the returned word.

For Clause 45 targets the block normally sends an address frame that loads the PHY's register pointer and then a data frame. A skip bit drops the address frame when the pointer is already known to be correct. The post-read-increment opcode also advances the stored register pointer after it completes, so software can walk a register block with repeated reads. MDC is derived from the system clock by a power-of-two divider chosen per transaction. The bidirectional MDIO pad lives outside the block and is reached through separate in, out and output-enable signals.

Top module: `mdio_mgmt_master`

## Requirements
- R1: A command-register write (select 1) with bit 22 set and a non-zero opcode in bits 17:16 starts a transaction. Bit 22 then reads 1 until the last frame has ended and reads 0 afterwards, with a frame count of one or two 64-bit frames.
- R2: Each frame is 32 ones, a 2-bit start code, a 2-bit opcode, the 5-bit port from target bits 20:16, a 5-bit device or register field, a 2-bit turnaround driven as 10 and 16 data bits, all sent most-significant bit first. Clause 45 frames use start code 00.
- R3: With target bit 31 clear and skip bit 18 clear, a Clause 45 address frame is sent first (opcode 00, device from target bits 25:21, data from target bits 15:0). It is followed by a data frame whose opcode equals the command opcode (01 write, 10 read with increment, 11 read).
- R4: With skip bit 18 set, a Clause 45 transaction sends only the data frame.
- R5: On a read data frame, MDIO output-enable is low for the two turnaround bits and the 16 data bits. The bits on the MDIO input at the 16 data-bit MDC rising edges are readable in command bits 15:0 once bit 22 is clear.
- R6: MDC idles low. Its period is 4 << S system clocks, where S is command bits 21:19. MDIO output changes only when MDC falls.
- R7: With target bit 31 set, a Clause 22 frame is sent with start code 01 and the register field taken from target bits 4:0. Opcode 01 is sent as a write and opcodes 10 and 11 are both sent as read code 10.
- R8: A Clause 22 start request is rejected when the target port (bits 20:16) is 4 or higher or its bit in the port-enable register (select 2, bits 3:0) is clear. No frame is sent, bit 22 stays 0 and c22_err goes high. c22_err stays high until the next accepted start.
- R9: Writes to any register while bit 22 is set are ignored.
- R10: A Clause 45 read with increment (opcode 10) adds one, modulo 2^16, to target bits 15:0 after it completes.
- R11: After reset, all three registers read 0, and c22_err, MDC and MDIO output-enable are low.
- R12: A command write with bit 22 set and opcode 00 starts nothing and leaves bit 22 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write select: 0 target, 1 command, 2 port-enable |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read select, same encoding as wr_sel |
| rd_data | output | 32 | Selected register contents |
| c22_err | output | 1 | Last start request was a rejected Clause 22 access |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO level from the pad |
| mdio_o | output | 1 | MDIO level to drive |
| mdio_oe | output | 1 | MDIO drive enable |

## Verification
On every cycle the embedded properties check that MDC stays low when no frame is active, that MDIO output holds still except at an MDC falling edge, that busy cannot drop before the final frame ends, that writes during busy leave the stored fields untouched, and that an out-of-range Clause 22 start is turned into an error with no busy. Only the bench scenarios can show frame content bit by bit: the address-then-data pairing against the skip bit, the Clause 22 opcode folding, turnaround release, read-word capture from a modelled PHY, the measured MDC period for several clock ranges and the pointer increment with wrap-around.

// File: rtl/mdio_mm_pkg.sv
package mdio_mm_pkg;

  localparam int FRAME_BITS = 64;
  localparam int DATA_BITS  = 16;

  localparam logic [1:0] OP_ADR   = 2'b00;
  localparam logic [1:0] OP_WR    = 2'b01;
  localparam logic [1:0] OP_RDINC = 2'b10;
  localparam logic [1:0] OP_RD    = 2'b11;

  localparam logic [1:0] ST_C22 = 2'b01;
  localparam logic [1:0] ST_C45 = 2'b00;

  typedef enum logic [1:0] {
    SEL_TGT  = 2'd0,
    SEL_CMD  = 2'd1,
    SEL_PORT = 2'd2
  } reg_sel_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_START = 2'd1,
    SQ_ADDR  = 2'd2,
    SQ_DATA  = 2'd3
  } seq_e;

  // Serial frame: preamble, start, opcode, port, dev/reg, turnaround, data
  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic [1:0]  st,
    input logic [1:0]  op,
    input logic [4:0]  pa,
    input logic [4:0]  ra,
    input logic [15:0] d
  );
    return {32'hFFFF_FFFF, st, op, pa, ra, 2'b10, d};
  endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);
  localparam int CNT_W = 1 << SEL_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   half_full;
  logic [CNT_W-1:0] lim;
  logic             mdc_q, mdc_d;
  logic             tick;

  // Half period = 2 << sel system clocks
  assign half_full = (CNT_W+1)'(2) << sel;
  assign lim       = CNT_W'(half_full - 1'b1);

  always_comb begin
    tick     = run && (cnt_q == lim);
    rise_stb = tick && !mdc_q;
    fall_stb = tick && mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      mdc_d = !mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
      mdc_d = mdc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc = mdc_q;

  // R6
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine #(
  parameter int FB = 64,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FB-1:0] frame,
  input  logic          rd_mode,
  input  logic          rise_stb,
  input  logic          fall_stb,
  input  logic          mdio_i,
  output logic          mdio_o,
  output logic          mdio_oe,
  output logic          active,
  output logic          done,
  output logic [DW-1:0] rd_word
);
  localparam int CW      = $clog2(FB);
  localparam int REL_POS = FB - DW - 2;
  localparam int CAP_POS = FB - DW;

  logic [FB-1:0] sreg_q, sreg_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;
  logic          rd_q, rd_d;
  logic          done_q, done_d;
  logic [DW-1:0] cap_q, cap_d;

  always_comb begin
    sreg_d = sreg_q;
    cnt_d  = cnt_q;
    act_d  = act_q;
    rd_d   = rd_q;
    cap_d  = cap_q;
    done_d = 1'b0;
    if (load) begin
      sreg_d = frame;
      cnt_d  = '0;
      act_d  = 1'b1;
      rd_d   = rd_mode;
    end else if (act_q) begin
      if (rise_stb && rd_q && (cnt_q >= CW'(CAP_POS)))
        cap_d = {cap_q[DW-2:0], mdio_i};
      if (fall_stb) begin
        if (cnt_q == CW'(FB-1)) begin
          act_d  = 1'b0;
          done_d = 1'b1;
        end else begin
          sreg_d = {sreg_q[FB-2:0], 1'b0};
          cnt_d  = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      rd_q   <= 1'b0;
      done_q <= 1'b0;
      cap_q  <= '0;
    end else begin
      sreg_q <= sreg_d;
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      rd_q   <= rd_d;
      done_q <= done_d;
      cap_q  <= cap_d;
    end
  end

  assign mdio_o  = sreg_q[FB-1];
  assign mdio_oe = act_q && !(rd_q && (cnt_q >= CW'(REL_POS)));
  assign active  = act_q;
  assign done    = done_q;
  assign rd_word = cap_q;

  // R6
  mdio_change_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && $past(act_q) && !$past(fall_stb)) |-> $stable(mdio_o));

endmodule

// File: rtl/mdio_host_ctrl.sv
module mdio_host_ctrl
  import mdio_mm_pkg::*;
#(
  parameter int C22_PORTS = 4,
  parameter int SEL_W     = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [1:0]            wr_sel,
  input  logic [31:0]           wr_data,
  input  logic [1:0]            rd_sel,
  output logic [31:0]           rd_data,
  output logic                  c22_err,
  output logic                  sh_load,
  output logic [FRAME_BITS-1:0] sh_frame,
  output logic                  sh_rd,
  input  logic                  sh_done,
  input  logic [DATA_BITS-1:0]  sh_word,
  output logic [SEL_W-1:0]      csel
);
  localparam int PSW = (C22_PORTS > 1) ? $clog2(C22_PORTS) : 1;
  localparam int CMD_PAD = 32 - (DATA_BITS + 3 + SEL_W + 1);

  logic [31:0]          addr_q, addr_d;
  logic [C22_PORTS-1:0] port_q, port_d;
  logic [DATA_BITS-1:0] data_q, data_d;
  logic [1:0]           op_q, op_d;
  logic                 skip_q, skip_d;
  logic [SEL_W-1:0]     csel_q, csel_d;
  logic                 busy_q, busy_d;
  logic                 err_q, err_d;
  seq_e                 st_q, st_d;

  logic                 c22, port_ok, start_req, reject, need_addr, use_afrm;
  logic [4:0]           pa, da;
  logic [1:0]           op22;
  logic [DATA_BITS-1:0] wdat;
  logic [FRAME_BITS-1:0] afrm, dfrm;

  assign c22       = addr_q[31];
  assign pa        = addr_q[20:16];
  assign da        = addr_q[25:21];
  assign port_ok   = (32'(pa) < C22_PORTS) && port_q[pa[PSW-1:0]];
  assign start_req = wr_en && (wr_sel == SEL_CMD) && !busy_q &&
                     wr_data[22] && (wr_data[17:16] != OP_ADR);
  assign reject    = start_req && c22 && !port_ok;
  assign need_addr = !c22 && !skip_q;
  assign use_afrm  = (st_q == SQ_START) && need_addr;
  assign op22      = (op_q == OP_WR) ? OP_WR : OP_RDINC;
  assign wdat      = (op_q == OP_WR) ? data_q : '0;
  assign afrm      = build_frame(ST_C45, OP_ADR, pa, da, addr_q[15:0]);
  assign dfrm      = c22 ? build_frame(ST_C22, op22, pa, addr_q[4:0], wdat)
                         : build_frame(ST_C45, op_q, pa, da, wdat);

  always_comb begin
    addr_d = addr_q;
    port_d = port_q;
    data_d = data_q;
    op_d   = op_q;
    skip_d = skip_q;
    csel_d = csel_q;
    busy_d = busy_q;
    err_d  = err_q;
    st_d   = st_q;
    if (wr_en && !busy_q) begin
      case (wr_sel)
        SEL_TGT:  addr_d = wr_data;
        SEL_PORT: port_d = wr_data[C22_PORTS-1:0];
        SEL_CMD: begin
          data_d = wr_data[DATA_BITS-1:0];
          op_d   = wr_data[17:16];
          skip_d = wr_data[18];
          csel_d = wr_data[19 +: SEL_W];
          if (start_req) begin
            if (reject) begin
              err_d = 1'b1;
            end else begin
              err_d  = 1'b0;
              busy_d = 1'b1;
              st_d   = SQ_START;
            end
          end
        end
        default: ;
      endcase
    end
    case (st_q)
      SQ_START: st_d = need_addr ? SQ_ADDR : SQ_DATA;
      SQ_ADDR:  if (sh_done) st_d = SQ_DATA;
      SQ_DATA: begin
        if (sh_done) begin
          st_d   = SQ_IDLE;
          busy_d = 1'b0;
          if (op_q != OP_WR)
            data_d = sh_word;
          if ((op_q == OP_RDINC) && !c22)
            addr_d[15:0] = addr_q[15:0] + 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      port_q <= '0;
      data_q <= '0;
      op_q   <= '0;
      skip_q <= 1'b0;
      csel_q <= '0;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      st_q   <= SQ_IDLE;
    end else begin
      addr_q <= addr_d;
      port_q <= port_d;
      data_q <= data_d;
      op_q   <= op_d;
      skip_q <= skip_d;
      csel_q <= csel_d;
      busy_q <= busy_d;
      err_q  <= err_d;
      st_q   <= st_d;
    end
  end

  assign sh_load  = (st_q == SQ_START) || ((st_q == SQ_ADDR) && sh_done);
  assign sh_frame = use_afrm ? afrm : dfrm;
  assign sh_rd    = !use_afrm && (op_q != OP_WR);
  assign csel     = csel_q;
  assign c22_err  = err_q;

  always_comb begin
    case (rd_sel)
      SEL_TGT:  rd_data = addr_q;
      SEL_CMD:  rd_data = {{CMD_PAD{1'b0}}, busy_q, csel_q, skip_q, op_q, data_q};
      SEL_PORT: rd_data = 32'(port_q);
      default:  rd_data = '0;
    endcase
  end

  // R1
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !sh_done) |=> busy_q);

  // R9
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wr_en && !sh_done) |=>
      ($stable(addr_q) && $stable(port_q) && $stable(op_q) && $stable(csel_q)));

  // R8
  c22_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && wr_en && (wr_sel == SEL_CMD) && wr_data[22] &&
     (wr_data[17:16] != 2'b00) && addr_q[31] && (32'(addr_q[20:16]) >= C22_PORTS))
      |=> (!busy_q && c22_err));

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mm_pkg::*;
#(
  parameter int C22_PORTS = 4,
  parameter int SEL_W     = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_sel,
  output logic [31:0] rd_data,
  output logic        c22_err,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic                  sh_load, sh_rd, sh_done, sh_active;
  logic [FRAME_BITS-1:0] sh_frame;
  logic [DATA_BITS-1:0]  sh_word;
  logic [SEL_W-1:0]      csel;
  logic                  rise_stb, fall_stb;

  mdio_host_ctrl #(.C22_PORTS(C22_PORTS), .SEL_W(SEL_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .rd_sel   (rd_sel),
    .rd_data  (rd_data),
    .c22_err  (c22_err),
    .sh_load  (sh_load),
    .sh_frame (sh_frame),
    .sh_rd    (sh_rd),
    .sh_done  (sh_done),
    .sh_word  (sh_word),
    .csel     (csel)
  );

  mdio_mdc_gen #(.SEL_W(SEL_W)) u_mdc (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (sh_active),
    .sel      (csel),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_frame_engine #(.FB(FRAME_BITS), .DW(DATA_BITS)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sh_load),
    .frame    (sh_frame),
    .rd_mode  (sh_rd),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .mdio_i   (mdio_i),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .active   (sh_active),
    .done     (sh_done),
    .rd_word  (sh_word)
  );

endmodule

// File: tb/sim_mdio_mgmt_master.sv
`timescale 1ns/1ps
module sim_mdio_mgmt_master;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic [1:0]  rd_sel;
  logic [31:0] rd_data;
  logic        c22_err;
  logic        mdc;
  logic        mdio_i;
  logic        mdio_o;
  logic        mdio_oe;

  int nchk;
  int nfail;

  logic [127:0] mon_o;
  logic [127:0] mon_oe;
  int           mon_n;
  time          t_r0;
  time          t_r1;
  logic [15:0]  phy_word;

  mdio_mgmt_master u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .c22_err(c22_err), .mdc(mdc),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Bus monitor: capture what the PHY would see at each MDC rising edge
  always @(posedge mdc) begin
    if (mon_n < 128) begin
      mon_o[mon_n]  = mdio_o;
      mon_oe[mon_n] = mdio_oe;
    end
    if (mon_n == 0) t_r0 = $time;
    if (mon_n == 1) t_r1 = $time;
    mon_n = mon_n + 1;
  end

  // PHY model: present read data after MDC falls
  always @(negedge mdc) begin
    if ((mon_n % 64) >= 48)
      mdio_i = phy_word[63 - (mon_n % 64)];
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail = nfail + 1;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk = nchk + 1;
    if (!ok) begin
      nfail = nfail + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk);
    rd_sel = s;
    #1 v = rd_data;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 80000; i++) begin
      rd(2'd1, v);
      if (!v[22]) break;
    end
  endtask

  function automatic logic [63:0] exp_frame(input logic [1:0] st, input logic [1:0] op,
                                            input logic [4:0] pa, input logic [4:0] ra,
                                            input logic [15:0] d);
    return {32'hFFFF_FFFF, st, op, pa, ra, 2'b10, d};
  endfunction

  function automatic int frame_mism(input int base, input logic [63:0] ef, input bit rdf);
    int m = 0;
    for (int i = 0; i < 64; i++) begin
      if (rdf && i >= 46) begin
        if (mon_oe[base+i] !== 1'b0) m++;
      end else begin
        if (mon_oe[base+i] !== 1'b1 || mon_o[base+i] !== ef[63-i]) m++;
      end
    end
    return m;
  endfunction

  task automatic txn(input bit c22, input logic [4:0] pa, input logic [4:0] da,
                     input logic [15:0] ra, input logic [1:0] op, input bit skip,
                     input logic [2:0] sel, input logic [15:0] wd, input logic [15:0] phy,
                     input bit poke, input string ftag);
    logic [31:0] av;
    logic [31:0] v;
    logic [63:0] fa;
    logic [63:0] fd;
    int nfr;
    bit rdop;
    int m;
    av = {c22, 5'b0, da, pa, ra};
    rdop = (op != 2'b01);
    wr(2'd0, av);
    phy_word = phy;
    mon_n = 0;
    wr(2'd1, {9'b0, 1'b1, sel, skip, op, wd});
    if (poke) begin
      repeat (20) @(negedge clk);
      wr(2'd0, ~av);
      wr(2'd2, 32'hF);
      wr(2'd1, {9'b0, 1'b1, ~sel, ~skip, 2'b01, ~wd});
    end
    wait_idle();
    nfr = (!c22 && !skip) ? 2 : 1;
    // R1: frame count equals the transaction shape
    chk(mon_n == nfr*64, "R1", 64'(mon_n), 64'(nfr*64));
    fd = c22 ? exp_frame(2'b01, (op == 2'b01) ? 2'b01 : 2'b10, pa, ra[4:0], wd)
             : exp_frame(2'b00, op, pa, da, wd);
    if (nfr == 2) begin
      fa = exp_frame(2'b00, 2'b00, pa, da, ra);
      m = frame_mism(0, fa, 1'b0);
      chk(m == 0, "R3 address frame", 64'(m), 64'd0);
    end
    m = frame_mism((nfr-1)*64, fd, rdop);
    chk(m == 0, ftag, 64'(m), 64'd0);
    rd(2'd1, v);
    if (rdop) chk(v[15:0] == phy, "R5 read word", 64'(v[15:0]), 64'(phy));
    else      chk(v[15:0] == wd, "R9 write data kept", 64'(v[15:0]), 64'(wd));
    chk(v[21:16] == {sel, skip, op}, "R9 command fields", 64'(v[21:16]), 64'({sel, skip, op}));
    // R6: MDC period
    chk((t_r1 - t_r0) == time'((4 << sel) * 8), "R6 period", 64'(t_r1 - t_r0), 64'((4 << sel) * 8));
    rd(2'd0, v);
    if (!c22 && op == 2'b10) begin
      // R10 pointer advance
      chk(v == {av[31:16], ra + 16'd1}, "R10 increment", 64'(v), 64'({av[31:16], ra + 16'd1}));
    end else begin
      chk(v == av, "R9 target kept", 64'(v), 64'(av));
    end
  endtask

  initial begin
    logic [31:0] v;
    int n0;
    nchk = 0; nfail = 0; mon_n = 0;
    wr_en = 0; wr_sel = 0; wr_data = 0; rd_sel = 0; mdio_i = 0; phy_word = 0;
    t_r0 = 0; t_r1 = 0;
    void'($urandom(32'h1234_5a5a));
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    rd(2'd0, v); chk(v == 0, "R11 target", 64'(v), 0);
    rd(2'd1, v); chk(v == 0, "R11 command", 64'(v), 0);
    rd(2'd2, v); chk(v == 0, "R11 port", 64'(v), 0);
    chk({c22_err, mdc, mdio_oe} == 3'b000, "R11 pins", 64'({c22_err, mdc, mdio_oe}), 0);

    // R3 Clause 45 write with address frame
    txn(1'b0, 5'd9, 5'd3, 16'hA55A, 2'b01, 1'b0, 3'd0, 16'h1234, 16'h0, 1'b0, "R2 data frame");
    // R4 skip the address frame, slower clock
    txn(1'b0, 5'd17, 5'd30, 16'h0F0F, 2'b01, 1'b1, 3'd3, 16'hBEEF, 16'h0, 1'b0, "R4 data only");
    // R5 Clause 45 read
    txn(1'b0, 5'd1, 5'd7, 16'h0042, 2'b11, 1'b0, 3'd1, 16'h0, 16'hC3A5, 1'b0, "R5 read frame");
    // R10 increment with wrap
    txn(1'b0, 5'd4, 5'd1, 16'hFFFF, 2'b10, 1'b1, 3'd0, 16'h0, 16'h5A0F, 1'b0, "R10 read frame");
    txn(1'b0, 5'd4, 5'd1, 16'h0100, 2'b10, 1'b0, 3'd0, 16'h0, 16'h0001, 1'b0, "R10 read frame");

    // R7 Clause 22 write and read with folded opcode
    wr(2'd2, 32'h4);
    txn(1'b1, 5'd2, 5'd0, 16'hFFE5, 2'b01, 1'b0, 3'd0, 16'h8001, 16'h0, 1'b0, "R7 write frame");
    wr(2'd2, 32'h2);
    txn(1'b1, 5'd1, 5'd0, 16'h001F, 2'b11, 1'b0, 3'd0, 16'h0, 16'h7E81, 1'b0, "R7 read frame");

    // R8 port out of range
    wr(2'd2, 32'hF);
    wr(2'd0, {1'b1, 5'b0, 5'd0, 5'd5, 16'h0003});
    n0 = mon_n;
    wr(2'd1, {9'b0, 1'b1, 3'd0, 1'b0, 2'b01, 16'h1111});
    rd(2'd1, v);
    chk(!v[22] && c22_err, "R8 port 5 rejected", 64'({v[22], c22_err}), 64'b01);
    repeat (40) @(negedge clk);
    chk(mon_n == n0, "R8 no MDC activity", 64'(mon_n), 64'(n0));
    // R8 port enable bit clear
    wr(2'd2, 32'h7);
    wr(2'd0, {1'b1, 5'b0, 5'd0, 5'd3, 16'h0003});
    wr(2'd1, {9'b0, 1'b1, 3'd0, 1'b0, 2'b11, 16'h0});
    rd(2'd1, v);
    chk(!v[22] && c22_err, "R8 disabled port", 64'({v[22], c22_err}), 64'b01);
    wr(2'd2, 32'h8);
    txn(1'b1, 5'd3, 5'd0, 16'h0007, 2'b01, 1'b0, 3'd0, 16'h2222, 16'h0, 1'b0, "R7 write frame");
    chk(!c22_err, "R8 error cleared", 64'(c22_err), 0);

    // R12 opcode 00 starts nothing
    n0 = mon_n;
    wr(2'd1, {9'b0, 1'b1, 3'd0, 1'b0, 2'b00, 16'h0});
    rd(2'd1, v);
    chk(!v[22], "R12 busy", 64'(v[22]), 0);
    repeat (40) @(negedge clk);
    chk(mon_n == n0, "R12 no frame", 64'(mon_n), 64'(n0));

    // R9 writes during busy
    txn(1'b0, 5'd12, 5'd2, 16'h3344, 2'b01, 1'b0, 3'd0, 16'h6789, 16'h0, 1'b1, "R9 frame intact");
    rd(2'd2, v);
    chk(v == 32'h8, "R9 port kept", 64'(v), 64'h8);

    // Random transactions
    for (int k = 0; k < 12; k++) begin
      bit rc22;
      logic [4:0] rpa;
      rc22 = 1'($urandom % 2);
      rpa = rc22 ? 5'($urandom % 4) : 5'($urandom);
      if (rc22) wr(2'd2, 32'(1 << rpa));
      txn(rc22, rpa, 5'($urandom), 16'($urandom), 2'(1 + $urandom % 3), 1'($urandom % 2),
          3'($urandom % 3), 16'($urandom), 16'($urandom), 1'b0, "R2 random frame");
    end

    summary();
    $finish;
  end

endmodule